// File: doc/BRIEF.md
# I2C Bit-Slot Clock and Line Timing Generator

This block turns a 32-bit divider word into the SCL and SDA waveforms of an I2C master, one bit slot at a time. A byte sequencer above it hands over one command per slot: a data bit, a START, a repeated START or a STOP. The block shapes both lines for that slot and raises single-cycle strobes that mark where data is placed on SDA, where a receiver samples, where a bus condition edge falls and where the slot ends.

Each SCL phase is the programmed divider plus one, times a fixed prescale of eight input clocks. The low-phase divider sits in the lower halfword and the high-phase divider in the upper halfword. Data moves at the middle of the low phase. A repeated START stretches SCL high to twice the high time and pulls SDA down at seven eighths of one high time. Both lines read 1 for released and 0 for driven low. The sequencer is assumed to issue START only while SDA is released, and to use a repeated START otherwise.

Top module: `scl_timing_gen`

## Requirements
- R1: The low-phase divider is `div_i[15:0]`; SCL is held low for exactly (low divider + 1) * 8 cycles in every slot that has a low phase (data bit, repeated START, STOP).
- R2: The high-phase divider is `div_i[31:16]`; SCL is high for exactly (high divider + 1) * 8 cycles in a data-bit, START or STOP slot, and for twice that in a repeated-START slot.
- R3: Command code 1 is a data bit: SDA keeps its previous value for the first half of the low phase, takes `cmd_bit_i` at cycle L/2 of the low phase, where `drive_stb_o` pulses, and holds it through the high phase.
- R4: In a data-bit slot `sample_stb_o` pulses once, at cycle H/2 of the high phase (H being the high-phase length).
- R5: Command code 0 is a START: the slot has no low phase; SDA is driven low from its first cycle while SCL stays high for H cycles.
- R6: Command code 2 is a repeated START: SDA is released at the low-phase midpoint, SCL is then high for 2H cycles, and SDA falls at cycle 7H/8 of that high time.
- R7: Command code 3 is a STOP: SDA is driven low at the low-phase midpoint, SCL is high for H cycles with SDA low, then SDA is released and both lines stay released for H further cycles before the slot ends.
- R8: `bit_done_o` pulses in the last cycle of each slot; `cmd_ready_o` is high in that cycle and whenever no slot runs, and an accepted command starts its slot in the very next cycle. Between slots both lines hold their last values.
- R9: `div_i` is captured only when a command is accepted; changing it during a slot does not alter that slot.
- R10: While `en_i` is low, from the next cycle on both lines are released, all strobes are low and `cmd_ready_o` is low, so commands are ignored.
- R11: After reset both lines are released, all strobes are low and `cmd_ready_o` follows `en_i`.
- R12: `cond_stb_o` pulses in the cycle of each condition edge: the START SDA fall, the repeated-START SDA fall and the STOP SDA release.
- R13: While enabled, SDA never changes while SCL stays high except in a cycle marked by `cond_stb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable; low forces the lines released |
| div_i | input | 32 | High divider in 31:16, low divider in 15:0 |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 2 | 0 START, 1 data bit, 2 repeated START, 3 STOP |
| cmd_bit_i | input | 1 | Bit value for a data-bit command |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| scl_o | output | 1 | SCL level, 1 released |
| sda_o | output | 1 | SDA level, 1 released |
| drive_stb_o | output | 1 | SDA takes its new low-phase value this cycle |
| sample_stb_o | output | 1 | Receive sampling point of a data bit |
| cond_stb_o | output | 1 | Condition edge on SDA this cycle |
| bit_done_o | output | 1 | Last cycle of the current slot |

## Verification
The two functions that share a cycle are the end of one slot and the acceptance of the next command together with the capture of a new divider word. The bench keeps commands back to back, presents the next command and a different divider in the very cycle `bit_done_o` is high, and then scrambles `div_i` during the slot. It judges the outcome by rebuilding every cycle of the following slot arithmetically from the captured divider and comparing the lines and strobes, which shows both that no gap appeared and that the old slot ended at full length.

// File: rtl/sclgen_pkg.sv
// Shared types for the SCL timing generator.
package sclgen_pkg;
    // Slot command codes; the numeric values are part of the port contract.
    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_DATA    = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } sg_op_e;

    // Phase of the current slot; SCL is low only in PH_LOW.
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_FREE = 2'd3
    } sg_phase_e;
endpackage

// File: rtl/sclgen_div_latch.sv
// Captures the divider word at each command acceptance and derives all
// phase lengths and event points from it.
// Assumes PRE_LOG2 >= 3 so that seven eighths of a high phase is exact.
module sclgen_div_latch #(
    parameter int DIV_W    = 16,
    parameter int PRE_LOG2 = 3,
    parameter int CNT_W    = DIV_W + PRE_LOG2 + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [2*DIV_W-1:0] div_i,
    output logic [CNT_W-1:0]   low_end_o,
    output logic [CNT_W-1:0]   half_low_o,
    output logic [CNT_W-1:0]   high_end1_o,
    output logic [CNT_W-1:0]   high_end2_o,
    output logic [CNT_W-1:0]   half_high_o,
    output logic [CNT_W-1:0]   fall_pt_o
);
    localparam int PAD = CNT_W - DIV_W - 1;

    logic [DIV_W-1:0] lo_q, hi_q;
    logic [DIV_W:0]   lo_p1, hi_p1;
    logic [CNT_W-1:0] low_len, high_len;

    // Hold the divider fields for the whole slot; update only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (load_i) begin
            lo_q <= div_i[DIV_W-1:0];
            hi_q <= div_i[2*DIV_W-1:DIV_W];
        end
    end

    // Apply the implicit +1 and the fixed prescale, then derive event points.
    always_comb begin
        lo_p1       = {1'b0, lo_q} + {{DIV_W{1'b0}}, 1'b1};
        hi_p1       = {1'b0, hi_q} + {{DIV_W{1'b0}}, 1'b1};
        low_len     = {{PAD{1'b0}}, lo_p1} << PRE_LOG2;
        high_len    = {{PAD{1'b0}}, hi_p1} << PRE_LOG2;
        low_end_o   = low_len - 1'b1;
        half_low_o  = low_len >> 1;
        high_end1_o = high_len - 1'b1;
        high_end2_o = (high_len << 1) - 1'b1;
        half_high_o = high_len >> 1;
        fall_pt_o   = high_len - (high_len >> 3);
    end
endmodule

// File: rtl/sclgen_phase_ctrl.sv
// Slot state machine: accepts commands, walks the low, high and bus-free
// phases with one counter, and tracks the SDA level left by each slot.
// Assumes the length inputs change only in the cycle after load_o.
module sclgen_phase_ctrl
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cmd_valid_i,
    input  sg_op_e           cmd_op_i,
    input  logic             cmd_bit_i,
    input  logic [CNT_W-1:0] low_end_i,
    input  logic [CNT_W-1:0] high_end1_i,
    input  logic [CNT_W-1:0] high_end2_i,
    output sg_phase_e        phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output sg_op_e           op_o,
    output logic             bit_o,
    output logic             sda_r_o,
    output logic             cmd_ready_o,
    output logic             load_o,
    output logic             bit_done_o
);
    sg_phase_e        phase_q;
    logic [CNT_W-1:0] cnt_q;
    sg_op_e           op_q;
    logic             bit_q, sda_q;
    logic [CNT_W-1:0] high_end;
    logic             last_cycle, final_sda;

    // Pick the high-phase end point and the SDA level a slot leaves behind.
    always_comb begin
        high_end   = (op_q == OP_RESTART) ? high_end2_i : high_end1_i;
        last_cycle = ((phase_q == PH_HIGH) && (op_q != OP_STOP) && (cnt_q == high_end)) ||
                     ((phase_q == PH_FREE) && (cnt_q == high_end1_i));
        case (op_q)
            OP_DATA: final_sda = bit_q;
            OP_STOP: final_sda = 1'b1;
            default: final_sda = 1'b0;
        endcase
    end

    assign cmd_ready_o = en_i && ((phase_q == PH_WAIT) || last_cycle);
    assign load_o      = cmd_valid_i && cmd_ready_o;
    assign bit_done_o  = last_cycle;

    // Advance phase and counter; a disable or reset parks the bus released.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            phase_q <= PH_WAIT;
            cnt_q   <= '0;
            op_q    <= OP_START;
            bit_q   <= 1'b1;
            sda_q   <= 1'b1;
        end else begin
            if (last_cycle) sda_q <= final_sda;
            if (load_o) begin
                phase_q <= (cmd_op_i == OP_START) ? PH_HIGH : PH_LOW;
                cnt_q   <= '0;
                op_q    <= cmd_op_i;
                bit_q   <= cmd_bit_i;
            end else begin
                case (phase_q)
                    PH_LOW: begin
                        if (cnt_q == low_end_i) begin
                            phase_q <= PH_HIGH;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (cnt_q == high_end) begin
                            phase_q <= (op_q == OP_STOP) ? PH_FREE : PH_WAIT;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_FREE: begin
                        if (cnt_q == high_end1_i) begin
                            phase_q <= PH_WAIT;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign phase_o = phase_q;
    assign cnt_o   = cnt_q;
    assign op_o    = op_q;
    assign bit_o   = bit_q;
    assign sda_r_o = sda_q;

    // The low-phase counter never passes the captured low length.
    assert_low_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOW) |-> (cnt_q <= low_end_i));

    // The high-phase counter never passes the length chosen for this slot.
    assert_high_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH) |-> (cnt_q <= high_end));

    // A slot end is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done_o |=> !bit_done_o);

    // Phase lengths stay frozen while a slot runs without a new acceptance.
    assert_div_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q != PH_WAIT) && !load_o) |=> ($stable(low_end_i) && $stable(high_end1_i)));
endmodule

// File: rtl/sclgen_line_shaper.sv
// Decodes the slot state into SCL, SDA and the drive, sample and condition
// strobes. Purely combinational; assumes the state comes from registers.
module sclgen_line_shaper
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  sg_phase_e        phase_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  sg_op_e           op_i,
    input  logic             bit_i,
    input  logic             sda_r_i,
    input  logic [CNT_W-1:0] half_low_i,
    input  logic [CNT_W-1:0] half_high_i,
    input  logic [CNT_W-1:0] fall_pt_i,
    output logic             scl_o,
    output logic             sda_o,
    output logic             drive_stb_o,
    output logic             sample_stb_o,
    output logic             cond_stb_o
);
    logic low_tgt;

    // Shape both lines and the strobes for the current phase position.
    always_comb begin
        scl_o        = (phase_i != PH_LOW);
        drive_stb_o  = 1'b0;
        sample_stb_o = 1'b0;
        cond_stb_o   = 1'b0;
        case (op_i)
            OP_DATA:    low_tgt = bit_i;
            OP_RESTART: low_tgt = 1'b1;
            default:    low_tgt = 1'b0;
        endcase
        case (phase_i)
            PH_LOW: begin
                sda_o       = (cnt_i >= half_low_i) ? low_tgt : sda_r_i;
                drive_stb_o = (cnt_i == half_low_i);
            end
            PH_HIGH: begin
                case (op_i)
                    OP_DATA: begin
                        sda_o        = bit_i;
                        sample_stb_o = (cnt_i == half_high_i);
                    end
                    OP_RESTART: begin
                        sda_o      = (cnt_i < fall_pt_i);
                        cond_stb_o = (cnt_i == fall_pt_i);
                    end
                    OP_START: begin
                        sda_o      = 1'b0;
                        cond_stb_o = (cnt_i == '0);
                    end
                    default: sda_o = 1'b0;
                endcase
            end
            PH_FREE: begin
                sda_o      = 1'b1;
                cond_stb_o = (cnt_i == '0);
            end
            default: sda_o = sda_r_i;
        endcase
    end
endmodule

// File: rtl/scl_timing_gen.sv
// Top of the SCL timing generator: divider capture, slot control and line
// shaping. Assumes the sequencer issues START only while SDA is released.
module scl_timing_gen #(
    parameter int DIV_W    = 16,
    parameter int PRE_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [2*DIV_W-1:0] div_i,
    input  logic               cmd_valid_i,
    input  logic [1:0]         cmd_op_i,
    input  logic               cmd_bit_i,
    output logic               cmd_ready_o,
    output logic               scl_o,
    output logic               sda_o,
    output logic               drive_stb_o,
    output logic               sample_stb_o,
    output logic               cond_stb_o,
    output logic               bit_done_o
);
    import sclgen_pkg::*;

    localparam int CNT_W = DIV_W + PRE_LOG2 + 2;

    logic [CNT_W-1:0] low_end, half_low, high_end1, high_end2, half_high, fall_pt;
    logic [CNT_W-1:0] cnt;
    sg_phase_e        phase;
    sg_op_e           op;
    logic             bit_v, sda_r, load;

    sclgen_div_latch #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2), .CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load_i(load), .div_i(div_i),
        .low_end_o(low_end), .half_low_o(half_low), .high_end1_o(high_end1),
        .high_end2_o(high_end2), .half_high_o(half_high), .fall_pt_o(fall_pt)
    );

    sclgen_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .cmd_valid_i(cmd_valid_i),
        .cmd_op_i(sg_op_e'(cmd_op_i)), .cmd_bit_i(cmd_bit_i),
        .low_end_i(low_end), .high_end1_i(high_end1), .high_end2_i(high_end2),
        .phase_o(phase), .cnt_o(cnt), .op_o(op), .bit_o(bit_v), .sda_r_o(sda_r),
        .cmd_ready_o(cmd_ready_o), .load_o(load), .bit_done_o(bit_done_o)
    );

    sclgen_line_shaper #(.CNT_W(CNT_W)) u_shape (
        .phase_i(phase), .cnt_i(cnt), .op_i(op), .bit_i(bit_v), .sda_r_i(sda_r),
        .half_low_i(half_low), .half_high_i(half_high), .fall_pt_i(fall_pt),
        .scl_o(scl_o), .sda_o(sda_o), .drive_stb_o(drive_stb_o),
        .sample_stb_o(sample_stb_o), .cond_stb_o(cond_stb_o)
    );

    // Data is placed only while SCL is low.
    assert_drive_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb_o |-> !scl_o);

    // Sampling happens well inside a high phase.
    assert_sample_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> (scl_o && $past(scl_o)));

    // A disable releases the bus and silences every strobe one cycle later.
    assert_released_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (scl_o && sda_o && !drive_stb_o && !sample_stb_o && !cond_stb_o && !bit_done_o));

    // SDA moves under a high SCL only at a marked condition edge.
    assert_sda_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && scl_o && $past(scl_o) && !cond_stb_o) |-> $stable(sda_o));
endmodule

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;
    localparam int C_START = 0, C_DATA = 1, C_RESTART = 2, C_STOP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b1;
    logic [31:0] div_i = '0;
    logic        cmd_valid_i = 1'b0;
    logic [1:0]  cmd_op_i = '0;
    logic        cmd_bit_i = 1'b0;
    logic        cmd_ready_o, scl_o, sda_o, drive_stb_o, sample_stb_o, cond_stb_o, bit_done_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 0;
    bit  line_sda = 1'b1;

    scl_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_bit_i(cmd_bit_i),
        .cmd_ready_o(cmd_ready_o), .scl_o(scl_o), .sda_o(sda_o),
        .drive_stb_o(drive_stb_o), .sample_stb_o(sample_stb_o),
        .cond_stb_o(cond_stb_o), .bit_done_o(bit_done_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Released bus, no strobes; ready as given.
    task automatic check_parked(input string req, input bit exp_ready);
        int st;
        st = {drive_stb_o, sample_stb_o, cond_stb_o, bit_done_o};
        check(scl_o && sda_o, req, "lines released (scl,sda)", {scl_o, sda_o}, 3);
        check(st == 0, req, "strobes quiet", st, 0);
        check(cmd_ready_o == exp_ready, req, "cmd_ready", cmd_ready_o, exp_ready);
    endtask

    // Issue one command at the current negedge and check every slot cycle.
    task automatic do_slot(input int op, input bit b, input int lo, input int hi);
        int L, H, len, j;
        int m_scl, m_sda, m_drv, m_smp, m_cond, m_done, m13;
        bit e_scl, e_sda, e_drv, e_smp, e_cond, e_done, tgt, p_scl, p_sda;
        string sreq;
        L = (lo + 1) * 8;
        H = (hi + 1) * 8;
        case (op)
            C_START:   len = H;
            C_DATA:    len = L + H;
            default:   len = L + 2 * H;
        endcase
        m_scl = 0; m_sda = 0; m_drv = 0; m_smp = 0; m_cond = 0; m_done = 0; m13 = 0;
        p_scl = 1'b0; p_sda = 1'b0;
        check(cmd_ready_o == 1'b1, "R8", "ready at issue", cmd_ready_o, 1);
        div_i       = {hi[15:0], lo[15:0]};
        cmd_op_i    = op[1:0];
        cmd_bit_i   = b;
        cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        div_i       = {16'(hi + 5), 16'(lo + 7)}; // R9: scramble during the slot
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            e_drv = 0; e_smp = 0; e_cond = 0; e_done = (k == len - 1);
            if (op == C_START) begin
                e_scl = 1; e_sda = 0; e_cond = (k == 0);
            end else if (k < L) begin
                e_scl = 0;
                e_drv = (k == L / 2);
                tgt   = (op == C_DATA) ? b : (op == C_RESTART);
                e_sda = (k < L / 2) ? line_sda : tgt;
            end else begin
                j = k - L;
                e_scl = 1;
                if (op == C_DATA) begin
                    e_sda = b; e_smp = (j == H / 2);
                end else if (op == C_RESTART) begin
                    e_sda = (j < 7 * (hi + 1)); e_cond = (j == 7 * (hi + 1));
                end else begin
                    e_sda = (j >= H); e_cond = (j == H);
                end
            end
            if (scl_o != e_scl) m_scl++;
            if (sda_o != e_sda) m_sda++;
            if (drive_stb_o != e_drv) m_drv++;
            if (sample_stb_o != e_smp) m_smp++;
            if (cond_stb_o != e_cond) m_cond++;
            if (bit_done_o != e_done || cmd_ready_o != e_done) m_done++;
            if (k > 0 && scl_o && p_scl && !cond_stb_o && sda_o != p_sda) m13++;
            p_scl = scl_o; p_sda = sda_o;
        end
        case (op)
            C_START:   begin sreq = "R5"; line_sda = 1'b0; end
            C_DATA:    begin sreq = "R3"; line_sda = b;    end
            C_RESTART: begin sreq = "R6"; line_sda = 1'b0; end
            default:   begin sreq = "R7"; line_sda = 1'b1; end
        endcase
        check(m_scl == 0, "R1 R2 R9", $sformatf("scl cycles off, op %0d lo %0d hi %0d", op, lo, hi), m_scl, 0);
        check(m_sda == 0, sreq, $sformatf("sda cycles off, op %0d lo %0d hi %0d", op, lo, hi), m_sda, 0);
        check(m_drv == 0, "R3", "drive strobe cycles off", m_drv, 0);
        check(m_smp == 0, "R4", "sample strobe cycles off", m_smp, 0);
        check(m_cond == 0, "R12", "condition strobe cycles off", m_cond, 0);
        check(m_done == 0, "R8", "done/ready cycles off", m_done, 0);
        check(m13 == 0, "R13", "sda moved under high scl", m13, 0);
    endtask

    // Let the block wait between slots and check that it holds the lines.
    task automatic idle_cycles(input int n);
        int st;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            st = {drive_stb_o, sample_stb_o, cond_stb_o, bit_done_o};
            check(scl_o == 1'b1 && sda_o == line_sda, "R8", "wait holds lines (scl,sda)",
                  {scl_o, sda_o}, {1'b1, line_sda});
            check(st == 0 && cmd_ready_o, "R8", "wait strobes/ready", {st, cmd_ready_o}, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_parked("R11", 1'b1);

        // Sweep a small divider space with a full transfer per setting.
        for (int lo = 0; lo < 4; lo++) begin
            for (int hi = 0; hi < 4; hi++) begin
                do_slot(C_START, 1'b0, lo, hi);
                do_slot(C_DATA, 1'b1, lo, hi);
                do_slot(C_DATA, 1'b0, hi, lo);
                idle_cycles(2);
                do_slot(C_RESTART, 1'b0, lo, hi);
                do_slot(C_DATA, 1'b1, lo, hi);
                do_slot(C_DATA, 1'b1, lo, hi);
                do_slot(C_STOP, 1'b0, hi, lo);
                idle_cycles(2);
            end
        end

        // Larger dividers, STOP followed at once by START.
        do_slot(C_START, 1'b0, 9, 5);
        do_slot(C_DATA, 1'b0, 9, 5);
        do_slot(C_STOP, 1'b0, 9, 5);
        do_slot(C_START, 1'b0, 2, 6);
        do_slot(C_DATA, 1'b0, 6, 2);
        do_slot(C_RESTART, 1'b0, 1, 3);
        do_slot(C_STOP, 1'b0, 3, 1);

        // R10: disable in the middle of a data slot, with a command pending.
        do_slot(C_START, 1'b0, 3, 3);
        div_i = 32'h0003_0003; cmd_op_i = 2'(C_DATA); cmd_bit_i = 1'b0; cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        repeat (20) @(negedge clk);
        en_i = 1'b0; cmd_valid_i = 1'b1; cmd_op_i = 2'(C_START);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_parked("R10", 1'b0);
        end
        cmd_valid_i = 1'b0; en_i = 1'b1; line_sda = 1'b1;
        @(negedge clk);
        check_parked("R10", 1'b1);
        do_slot(C_START, 1'b0, 1, 1);
        do_slot(C_DATA, 1'b1, 1, 1);
        do_slot(C_STOP, 1'b0, 1, 1);

        // R11: reset in the middle of a slot.
        do_slot(C_START, 1'b0, 2, 2);
        div_i = 32'h0002_0002; cmd_op_i = 2'(C_DATA); cmd_bit_i = 1'b0; cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        line_sda = 1'b1;
        check_parked("R11", 1'b1);
        @(negedge clk);
        check_parked("R11", 1'b1);
        do_slot(C_START, 1'b0, 0, 0);
        do_slot(C_STOP, 1'b0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule